// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Classifier

This block watches the row strobe, the two byte column strobes, the write strobe and the output-enable strobe of an EDO DRAM interface. It samples them with a fast system clock and names each memory cycle from the order in which the strobe edges arrive. All strobes are active low at the ports. They are assumed synchronous to `clk`, because a controller in the same design drives them. The block sits next to that controller as a checker. It reports one type code per finished access or refresh, and it predicts on each sample which byte lanes the memory would be driving onto the data pins. It raises an error when a write access starts its two byte strobes on different samples, and it keeps a wrapping tally of every type it reports.

An access is opened by the first column strobe that asserts while the row strobe is asserted. It is closed when the last column strobe releases. Write intent and output drive are tracked per byte lane. Refresh cycles are reported when the row strobe releases. Every registered output follows its deciding sample by one clock.

Top module: `strobe_cycle_monitor`

## Requirements
- R1: After reset, `cyc_valid`, `cyc_type`, `seq_err`, `drive` and all tallies are zero. Whenever `cyc_valid` is low, `cyc_type` reads 0 (standby).
- R2: If the row strobe asserts on a sample where a column strobe was already asserted on the previous sample, the cycle is a CAS-before-RAS refresh. It is reported as type 5 on the sample where the row strobe releases, and no lane is driven during it.
- R3: A row strobe pulse in which no access opens is reported as type 6 (RAS-only refresh) when the row strobe releases.
- R4: If a CAS-before-RAS refresh keeps the row strobe and a column strobe asserted for at least `SELF_CYCLES` further samples after its entry sample, it is reported as type 7 (self refresh) instead of 5.
- R5: The type of an access is reported when its last column strobe releases. The codes are: 1 read; 2 early write (write strobe asserted on the opening sample); 3 delayed write (write strobe asserted later, with no read of OE asserted before it); 4 read-modify-write (OE asserted with the write strobe released before the write strobe asserts).
- R6: Lane 0 (lower byte, `lcas_n`) and lane 1 (upper byte, `ucas_n`) are each predicted as driven one sample after row strobe, that lane's column strobe and OE are asserted with the write strobe released, outside refresh and outside an early-write access. With OE released, or the write strobe asserted, the lane is not driven.
- R7: A driven lane stays driven after its column strobe releases while the row strobe stays asserted, OE stays asserted and the write strobe stays released. OE releasing or the write strobe asserting in that phase turns the lane off, and it stays off until the next column access.
- R8: A driven lane turns off only after both the row strobe and its own column strobe have released, whichever releases later.
- R9: With the row strobe and both column strobes released, no lane is driven. No access opens while the row strobe is released, whatever the other strobes do.
- R10: `seq_err` pulses with the report of a write access (type 2, 3 or 4) whose two column strobes asserted on different samples. A staggered read raises no error.
- R11: The tally field k (`type_counts[k*CNT_W +: CNT_W]`) increments by one, wrapping, for each report of type k.
- R12: `cyc_valid` is a single-sample pulse. Releasing the row strobe after a cycle that held an access produces no further report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-sample pulse marking a report |
| cyc_type | output | 3 | Reported cycle type code |
| seq_err | output | 1 | Staggered byte strobes in a write access |
| drive | output | 2 | Predicted lane drive, bit 0 lower byte |
| type_counts | output | 8*CNT_W | Wrapping tally per type code |

## Verification
The bench builds the block with `SELF_CYCLES` = 4 and `CNT_W` = 8. With these values the threshold between a plain CAS-before-RAS refresh and a self refresh sits only a few samples apart, so both sides of it are driven directly. The tallies never wrap during the run, so they can be compared exactly at the end. The small configuration also allows a full sweep of lane choice (lower, upper, both together, staggered) against write timing (none, early, late) and OE, with each expected code derived from these rules. The sweep also covers every combination of the column, write and OE strobes with the row strobe released.

// File: rtl/mon_pkg.sv
`timescale 1ns/1ps
package mon_pkg;

    localparam int NUM_KINDS = 8;

    typedef enum logic [2:0] {
        CY_IDLE  = 3'd0,
        CY_READ  = 3'd1,
        CY_EWR   = 3'd2,
        CY_DWR   = 3'd3,
        CY_RMW   = 3'd4,
        CY_CBR   = 3'd5,
        CY_RONLY = 3'd6,
        CY_SELF  = 3'd7
    } cyc_kind_e;

    // strobe levels converted to active high
    typedef struct packed {
        logic       ras;
        logic [1:0] cas;   // [0] lower byte, [1] upper byte
        logic       we;
        logic       oe;
    } strobe_t;

    typedef struct packed {
        logic       ras_rise;
        logic       ras_fall;
        logic [1:0] cas_rise;
        logic       any_rise;
        logic       any_fall;
    } edges_t;

    function automatic cyc_kind_e access_kind(input logic early, input logic late,
                                              input logic read_seen);
        if (early)
            return CY_EWR;
        else if (late)
            return read_seen ? CY_RMW : CY_DWR;
        else
            return CY_READ;
    endfunction

endpackage

// File: rtl/mon_edge.sv
`timescale 1ns/1ps
module mon_edge
    import mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ras,
    input  logic [1:0] cas,
    output logic [1:0] prev_cas,
    output edges_t     ev
);

    logic       ras_q;
    logic [1:0] cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b0;
            cas_q <= 2'b00;
        end else begin
            ras_q <= ras;
            cas_q <= cas;
        end
    end

    always_comb begin
        ev.ras_rise = ras & ~ras_q;
        ev.ras_fall = ~ras & ras_q;
        ev.cas_rise = cas & ~cas_q;
        ev.any_rise = (|cas) & ~(|cas_q);
        ev.any_fall = ~(|cas) & (|cas_q);
    end

    assign prev_cas = cas_q;

endmodule

// File: rtl/mon_classify.sv
`timescale 1ns/1ps
module mon_classify
    import mon_pkg::*;
#(
    parameter int SELF_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  strobe_t    now,
    input  logic [1:0] prev_cas,
    input  edges_t     ev,
    output logic       rpt_valid,
    output cyc_kind_e  rpt_kind,
    output logic       rpt_err,
    output logic       lane_block
);

    localparam int              SC_W     = $clog2(SELF_CYCLES + 1);
    localparam logic [SC_W-1:0] SELF_LIM = SC_W'(SELF_CYCLES);

    logic            cbr_q, accessed_q, open_q;
    logic            early_q, late_q, rd_q, stag_q;
    logic [SC_W-1:0] hold_q;

    logic cbr_now, acc_start, early_eff;

    assign cbr_now    = ev.ras_rise & (|prev_cas);
    assign acc_start  = ev.any_rise & now.ras & ~cbr_q & ~cbr_now;
    assign early_eff  = acc_start ? now.we : early_q;
    assign lane_block = cbr_q | cbr_now | early_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            cbr_q      <= 1'b0;
            accessed_q <= 1'b0;
            open_q     <= 1'b0;
            early_q    <= 1'b0;
            late_q     <= 1'b0;
            rd_q       <= 1'b0;
            stag_q     <= 1'b0;
            hold_q     <= '0;
            rpt_valid  <= 1'b0;
            rpt_kind   <= CY_IDLE;
            rpt_err    <= 1'b0;
        end else begin
            rpt_valid <= 1'b0;
            rpt_kind  <= CY_IDLE;
            rpt_err   <= 1'b0;

            // row strobe entry and refresh dwell counter
            if (ev.ras_rise) begin
                cbr_q      <= cbr_now;
                accessed_q <= 1'b0;
                hold_q     <= '0;
            end else if (cbr_q && now.ras && (|now.cas) && hold_q != SELF_LIM) begin
                hold_q <= hold_q + 1'b1;
            end

            // column access tracking
            if (acc_start) begin
                open_q     <= 1'b1;
                accessed_q <= 1'b1;
                early_q    <= now.we;
                late_q     <= 1'b0;
                rd_q       <= ~now.we & now.oe;
                stag_q     <= 1'b0;
            end else if (open_q) begin
                if (ev.any_fall) begin
                    open_q    <= 1'b0;
                    early_q   <= 1'b0;
                    rpt_valid <= 1'b1;
                    rpt_kind  <= access_kind(early_q, late_q, rd_q);
                    rpt_err   <= stag_q & (early_q | late_q);
                end else begin
                    if (!early_q && now.we)
                        late_q <= 1'b1;
                    if (!late_q && !now.we && now.oe)
                        rd_q <= 1'b1;
                    if (|ev.cas_rise)
                        stag_q <= 1'b1;
                end
            end

            // row strobe release: refresh reports
            if (ev.ras_fall) begin
                cbr_q <= 1'b0;
                if (cbr_q) begin
                    rpt_valid <= 1'b1;
                    rpt_kind  <= (hold_q >= SELF_LIM) ? CY_SELF : CY_CBR;
                end else if (!accessed_q && !open_q) begin
                    rpt_valid <= 1'b1;
                    rpt_kind  <= CY_RONLY;
                end
            end
        end
    end

endmodule

// File: rtl/mon_lane.sv
`timescale 1ns/1ps
module mon_lane (
    input  logic clk,
    input  logic rst,
    input  logic ras,
    input  logic cas,
    input  logic we,
    input  logic oe,
    input  logic block,
    output logic drive
);

    logic drive_nxt;

    always_comb begin
        if (ras && cas)
            drive_nxt = oe & ~we & ~block;
        else
            drive_nxt = drive & (ras | cas) & oe & ~we;
    end

    always_ff @(posedge clk) begin
        if (rst)
            drive <= 1'b0;
        else
            drive <= drive_nxt;
    end

endmodule

// File: rtl/mon_tally.sv
`timescale 1ns/1ps
module mon_tally
    import mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid,
    input  logic [2:0]                 kind,
    output logic [NUM_KINDS*CNT_W-1:0] counts
);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bin
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (valid && kind == 3'(k))
                cnt <= cnt + 1'b1;
        end
        assign counts[k*CNT_W +: CNT_W] = cnt;
    end

endmodule

// File: rtl/strobe_cycle_monitor.sv
`timescale 1ns/1ps
module strobe_cycle_monitor
    import mon_pkg::*;
#(
    parameter int SELF_CYCLES = 1024,
    parameter int CNT_W       = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ras_n,
    input  logic                       ucas_n,
    input  logic                       lcas_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    output logic                       cyc_valid,
    output logic [2:0]                 cyc_type,
    output logic                       seq_err,
    output logic [1:0]                 drive,
    output logic [NUM_KINDS*CNT_W-1:0] type_counts
);

    strobe_t    now;
    edges_t     ev;
    logic [1:0] prev_cas;
    cyc_kind_e  kind;
    logic       lane_block;

    assign now.ras = ~ras_n;
    assign now.cas = {~ucas_n, ~lcas_n};
    assign now.we  = ~we_n;
    assign now.oe  = ~oe_n;

    mon_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .ras      (now.ras),
        .cas      (now.cas),
        .prev_cas (prev_cas),
        .ev       (ev)
    );

    mon_classify #(.SELF_CYCLES(SELF_CYCLES)) u_class (
        .clk        (clk),
        .rst        (rst),
        .now        (now),
        .prev_cas   (prev_cas),
        .ev         (ev),
        .rpt_valid  (cyc_valid),
        .rpt_kind   (kind),
        .rpt_err    (seq_err),
        .lane_block (lane_block)
    );

    assign cyc_type = kind;

    for (genvar b = 0; b < 2; b++) begin : g_lane
        mon_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .ras   (now.ras),
            .cas   (now.cas[b]),
            .we    (now.we),
            .oe    (now.oe),
            .block (lane_block),
            .drive (drive[b])
        );
    end

    mon_tally #(.CNT_W(CNT_W)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .valid  (cyc_valid),
        .kind   (kind),
        .counts (type_counts)
    );

endmodule

// File: rtl/mon_checker.sv
`timescale 1ns/1ps
module mon_checker (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       ucas_n,
    input logic       lcas_n,
    input logic       we_n,
    input logic       cyc_valid,
    input logic [2:0] cyc_type,
    input logic       seq_err,
    input logic [1:0] drive
);

    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> cyc_type == 3'd0);

    // R9
    standby_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n && ucas_n && lcas_n) |=> drive == 2'b00);

    // R6
    write_off_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> drive == 2'b00);

    // R10
    err_write_chk: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> cyc_valid && (cyc_type == 3'd2 || cyc_type == 3'd3 || cyc_type == 3'd4));

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> !cyc_valid);

endmodule

bind strobe_cycle_monitor mon_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .ucas_n    (ucas_n),
    .lcas_n    (lcas_n),
    .we_n      (we_n),
    .cyc_valid (cyc_valid),
    .cyc_type  (cyc_type),
    .seq_err   (seq_err),
    .drive     (drive)
);

// File: tb/strobe_cycle_monitor_bench.sv
`timescale 1ns/1ps
module strobe_cycle_monitor_bench;

    localparam int SC = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras = 1'b0, uc = 1'b0, lc = 1'b0, we = 1'b0, oe = 1'b0;

    logic          cyc_valid, seq_err;
    logic [2:0]    cyc_type;
    logic [1:0]    drive;
    logic [8*CW-1:0] type_counts;

    int  n_cmp = 0, n_bad = 0;
    int  exp_cnt[8];
    bit  done = 1'b0;

    always #2 clk = ~clk;

    strobe_cycle_monitor #(.SELF_CYCLES(SC), .CNT_W(CW)) u_strobe_cycle_monitor (
        .clk         (clk),
        .rst         (rst),
        .ras_n       (~ras),
        .ucas_n      (~uc),
        .lcas_n      (~lc),
        .we_n        (~we),
        .oe_n        (~oe),
        .cyc_valid   (cyc_valid),
        .cyc_type    (cyc_type),
        .seq_err     (seq_err),
        .drive       (drive),
        .type_counts (type_counts)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one sample of active-high strobe levels, then look after the edge
    task automatic step(input logic r, input logic u, input logic l,
                        input logic w, input logic o);
        @(negedge clk);
        ras = r; uc = u; lc = l; we = w; oe = o;
        @(posedge clk);
        #1;
    endtask

    // lanes: 0 lower, 1 upper, 2 both together, 3 staggered; wm: 0 none, 1 early, 2 late
    task automatic access(input int lanes, input int wm, input bit oep);
        logic w0, o0, uf, lf;
        int   et;
        w0 = (wm == 1);
        o0 = oep && (wm != 1);
        uf = (lanes != 0);
        lf = (lanes != 1);
        step(1, 0, 0, 0, 0);
        chk("R3 no report at row entry", cyc_valid, 0);
        if (lanes == 3) begin
            step(1, 0, 1, w0, o0);
            chk("R6 staggered first lane", drive, (o0 && !w0) ? 1 : 0);
        end
        step(1, uf, lf, w0, o0);
        chk("R6 lane drive", drive, (o0 && !w0) ? {uf, lf} : 0);
        step(1, uf, lf, w0, o0);
        chk("R6 lane drive held", drive, (o0 && !w0) ? {uf, lf} : 0);
        if (wm == 2) begin
            step(1, uf, lf, 1, o0);
            chk("R6 late write turns lanes off", drive, 0);
            step(1, uf, lf, 1, o0);
        end
        step(1, 0, 0, 0, 0);
        et = (wm == 1) ? 2 : (wm == 2) ? (oep ? 4 : 3) : 1;
        chk("R5 access report valid", cyc_valid, 1);
        chk("R5 access type", cyc_type, et);
        chk("R10 stagger error", seq_err, (lanes == 3 && wm != 0) ? 1 : 0);
        exp_cnt[et]++;
        step(0, 0, 0, 0, 0);
        chk("R12 no report at row release", cyc_valid, 0);
        chk("R9 standby lanes off", drive, 0);
    endtask

    task automatic cbr(input int extra);
        step(0, 0, 1, 0, 1);
        step(1, 0, 1, 0, 1);
        chk("R2 no drive in refresh", drive, 0);
        for (int i = 0; i < extra; i++) begin
            step(1, 0, 1, 0, 1);
            chk("R2 no drive in refresh", drive, 0);
            chk("R2 no early report", cyc_valid, 0);
        end
        step(0, 0, 1, 0, 1);
        chk("R4 refresh report valid", cyc_valid, 1);
        chk("R4 refresh type", cyc_type, (extra >= SC) ? 7 : 5);
        exp_cnt[(extra >= SC) ? 7 : 5]++;
        step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (exp_cnt[k]) exp_cnt[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", cyc_valid, 0);
        chk("R1 reset type", cyc_type, 0);
        chk("R1 reset err", seq_err, 0);
        chk("R1 reset drive", drive, 0);
        chk("R1 reset tallies", (type_counts == '0) ? 1 : 0, 1);
        @(negedge clk);
        rst = 1'b0;

        // R9: standby sweep with the row strobe released
        for (int c = 0; c < 16; c++) begin
            step(0, c[3], c[2], c[1], c[0]);
            chk("R9 standby drive", drive, 0);
            chk("R9 standby report", cyc_valid, 0);
        end
        step(0, 0, 0, 0, 0);

        // R5 R6 R10: lane x write timing x OE sweep
        for (int ln = 0; ln < 4; ln++)
            for (int wm = 0; wm < 3; wm++)
                for (int o = 0; o < 2; o++)
                    access(ln, wm, o[0]);

        // R3: RAS-only refresh
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        chk("R3 no drive without column", drive, 0);
        step(0, 0, 0, 0, 0);
        chk("R3 ras-only valid", cyc_valid, 1);
        chk("R3 ras-only type", cyc_type, 6);
        exp_cnt[6]++;

        // R2 R4: refresh around the self refresh threshold
        cbr(SC - 1);
        cbr(SC);
        cbr(0);

        // R7: extended output after column release
        step(1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 1);
        chk("R7 both lanes driven", drive, 3);
        step(1, 0, 0, 0, 1);
        chk("R7 read report", cyc_type, 1);
        chk("R7 held after column release", drive, 3);
        exp_cnt[1]++;
        step(1, 0, 0, 0, 1);
        chk("R7 still held", drive, 3);
        step(1, 0, 0, 0, 0);
        chk("R7 OE release turns off", drive, 0);
        step(1, 0, 0, 0, 1);
        chk("R7 stays off until next access", drive, 0);
        step(1, 1, 1, 0, 1);
        chk("R7 next access drives", drive, 3);
        step(1, 0, 0, 0, 1);
        chk("R7 held again", drive, 3);
        exp_cnt[1]++;
        step(1, 0, 0, 1, 1);
        chk("R7 write strobe turns off", drive, 0);
        step(1, 0, 0, 0, 1);
        chk("R7 stays off after write strobe", drive, 0);
        step(0, 0, 0, 0, 0);
        chk("R12 no report after accesses", cyc_valid, 0);

        // R8: row strobe releases before the column strobes
        step(1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 1);
        step(0, 1, 1, 0, 1);
        chk("R8 held past row release", drive, 3);
        chk("R12 no report with open access", cyc_valid, 0);
        step(0, 1, 1, 0, 1);
        chk("R8 still held", drive, 3);
        step(0, 0, 0, 0, 1);
        chk("R8 off after later release", drive, 0);
        chk("R5 read reported at column release", cyc_type, 1);
        exp_cnt[1]++;
        step(0, 0, 0, 0, 0);

        // R11: tallies
        for (int k = 0; k < 8; k++)
            chk($sformatf("R11 tally %0d", k), type_counts[k*CW +: CW], exp_cnt[k] % 256);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule